// File: doc/BRIEF.md
# Hierarchical Weighted Round-Robin Task Scheduler

This block chooses which of 32 scheduling queues receives the next service opportunity on a shared internal processing resource. Each queue presents an eligibility flag, a weight and a destination tag. Queue 0 sits above everything else and wins whenever it is eligible. The remaining 31 queues are arbitrated in one of two configurations. In the flat configuration they form a single weighted round-robin group. In the tiered configuration, queues 1 to 15 form an upper tier that strictly beats the lower tier of queues 16 to 31, and each tier runs its own weighted round robin.

Weighting uses per-queue credit counters. A queue may be picked while it holds credit, and each pick costs one credit. When every active queue of a tier is out of credit, the whole tier reloads from the weights. A circular scan starts just after the last queue granted in that tier. Each decision is presented on a valid/ready grant port that carries the queue index and its destination. The grant is held until it is accepted, and a new decision is taken on every cycle in which the port is free.

Top module: `task_sched_hwrr`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `gnt_valid` is low.
- R2: When queue 0 is eligible with a nonzero weight and the grant port is free, the next grant is queue 0, whatever the other queues are doing.
- R3: In flat mode (`tiered_mode`=0), with queues 1..31 continuously eligible and the grant always accepted, each queue receives exactly weight×K grants in the first K full rounds after reset.
- R4: In tiered mode (`tiered_mode`=1), no queue in 16..31 is granted while any queue in 1..15 is eligible with a nonzero weight.
- R5: Credit counters start at zero after reset. A queue with zero credit is passed over while another active queue in its tier has credit. When none has credit, every queue of the tier is reloaded to its weight, and the winner is charged one credit.
- R6: Each tier's scan begins at the queue after the last one it granted, wrapping from 31 to 0. Weights 3 and 1 on queues 2 and 3 alone therefore give the sequence 2,3,2,2,3,2,2,2,3,...
- R7: A queue with weight 0 is never granted, even when eligible.
- R8: While `gnt_valid` is high and `gnt_ready` is low, `gnt_valid`, `gnt_qid` and `gnt_dest` hold their values.
- R9: A decision is taken on every cycle in which the port is free (no grant, or a grant being accepted), and it appears on the outputs after the next clock edge, so grants can be back to back.
- R10: `gnt_dest` equals the 3-bit tag of the granted queue, sampled at decision time from bits [qid*3 +: 3] of `q_dest`.
- R11: If no queue is both eligible and nonzero-weighted when the port is free, `gnt_valid` is low after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| q_elig | input | 32 | Per-queue eligibility (queue has work) |
| q_weight | input | 128 | Per-queue weight, 4 bits each, queue i at [i*4 +: 4] |
| q_dest | input | 96 | Per-queue destination tag, 3 bits each, queue i at [i*3 +: 3] |
| tiered_mode | input | 1 | 0: queues 1..31 as one group; 1: 1..15 above 16..31. Change only while no grant is valid |
| gnt_ready | input | 1 | Consumer accepts the current grant |
| gnt_valid | output | 1 | A grant is presented |
| gnt_qid | output | 5 | Granted queue index |
| gnt_dest | output | 3 | Destination tag of the granted queue |

## Verification
Every decision is registered once. The bench changes inputs one nanosecond after a rising edge. The grant that those inputs produce is therefore due on the outputs after the following rising edge, and the bench compares it at the falling edge inside that cycle against a reference model that steps on the same edge. A stalled grant must remain unchanged on each falling edge until the cycle after `gnt_ready` rises. Handshakes are logged at the falling edge of the cycle in which they complete. The weight-ratio, tier-order, queue-0 and sequence checks are run on that log, and they discard the one grant that was already committed before a stimulus change.

// File: rtl/sched_pkg.sv
package sched_pkg;
    localparam int NUM_Q   = 32;
    localparam int QID_W   = $clog2(NUM_Q);
    localparam int NUM_ARB = 3;

    typedef enum logic [1:0] {
        ARB_FLAT  = 2'd0,
        ARB_UPPER = 2'd1,
        ARB_LOWER = 2'd2
    } arb_sel_e;

    // Membership of each arbiter: flat covers 1..NUM_Q-1, upper covers
    // 1..low_base-1, lower covers low_base..NUM_Q-1.
    function automatic logic [NUM_Q-1:0] tier_mask(input int arb, input int low_base);
        logic [NUM_Q-1:0] m;
        m = '0;
        for (int i = 1; i < NUM_Q; i++) begin
            case (arb)
                0:       m[i] = 1'b1;
                1:       m[i] = (i < low_base);
                default: m[i] = (i >= low_base);
            endcase
        end
        return m;
    endfunction
endpackage

// File: rtl/sched_rr_pick.sv
module sched_rr_pick #(
    parameter int N     = 32,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    input  logic [IDX_W-1:0] start,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    logic [N-1:0] upper;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            upper[i] = req[i] && (i >= int'(start));
        end
    end

    always_comb begin
        found = |req;
        idx   = '0;
        if (|upper) begin
            for (int i = N - 1; i >= 0; i--) begin
                if (upper[i]) idx = IDX_W'(i);
            end
        end else begin
            for (int i = N - 1; i >= 0; i--) begin
                if (req[i]) idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/sched_tier_arb.sv
module sched_tier_arb #(
    parameter int N     = 32,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     active,
    input  logic [N-1:0]     credit_nz,
    input  logic [N-1:0]     member,
    input  logic [IDX_W-1:0] ptr,
    output logic             found,
    output logic [IDX_W-1:0] idx,
    output logic             reload
);
    logic [N-1:0] cand_all;
    logic [N-1:0] cand_credit;
    logic [N-1:0] use_vec;

    always_comb begin
        cand_all    = active & member;
        cand_credit = cand_all & credit_nz;
        reload      = (cand_credit == '0) && (cand_all != '0);
        use_vec     = reload ? cand_all : cand_credit;
    end

    sched_rr_pick #(.N(N), .IDX_W(IDX_W)) u_pick (
        .req   (use_vec),
        .start (ptr),
        .found (found),
        .idx   (idx)
    );
endmodule

// File: rtl/task_sched_hwrr.sv
module task_sched_hwrr
    import sched_pkg::*;
#(
    parameter int WEIGHT_W = 4,
    parameter int DEST_W   = 3,
    parameter int LOW_BASE = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_Q-1:0]          q_elig,
    input  logic [NUM_Q*WEIGHT_W-1:0] q_weight,
    input  logic [NUM_Q*DEST_W-1:0]   q_dest,
    input  logic                      tiered_mode,
    input  logic                      gnt_ready,
    output logic                      gnt_valid,
    output logic [QID_W-1:0]          gnt_qid,
    output logic [DEST_W-1:0]         gnt_dest
);
    typedef struct packed {
        logic                                valid;
        logic [QID_W-1:0]                    qid;
        logic [DEST_W-1:0]                   dest;
        logic [NUM_ARB-1:0][QID_W-1:0]       ptr;
        logic [NUM_Q-1:0][WEIGHT_W-1:0]      credit;
    } st_t;

    st_t st_d, st_q;

    logic [NUM_Q-1:0][WEIGHT_W-1:0] weight;
    logic [NUM_Q-1:0]               active;
    logic [NUM_Q-1:0]               credit_nz;
    logic                           free;
    arb_sel_e                       sel;
    logic [QID_W-1:0]               win;

    logic [NUM_ARB-1:0]             arb_found;
    logic [NUM_ARB-1:0]             arb_reload;
    logic [NUM_ARB-1:0][QID_W-1:0]  arb_idx;
    logic [NUM_ARB-1:0][NUM_Q-1:0]  arb_mask;

    always_comb begin
        for (int i = 0; i < NUM_Q; i++) begin
            weight[i]    = q_weight[i*WEIGHT_W +: WEIGHT_W];
            active[i]    = q_elig[i] && (weight[i] != '0);
            credit_nz[i] = (st_q.credit[i] != '0);
        end
    end

    // One arbiter per tier configuration; the mode picks which one is used.
    for (genvar a = 0; a < NUM_ARB; a++) begin : g_arb
        assign arb_mask[a] = tier_mask(a, LOW_BASE);
        sched_tier_arb #(.N(NUM_Q), .IDX_W(QID_W)) u_tier (
            .active    (active),
            .credit_nz (credit_nz),
            .member    (arb_mask[a]),
            .ptr       (st_q.ptr[a]),
            .found     (arb_found[a]),
            .idx       (arb_idx[a]),
            .reload    (arb_reload[a])
        );
    end

    always_comb begin
        if (!tiered_mode)            sel = ARB_FLAT;
        else if (arb_found[ARB_UPPER]) sel = ARB_UPPER;
        else                         sel = ARB_LOWER;
    end

    always_comb begin
        st_d = st_q;
        free = !st_q.valid || gnt_ready;
        win  = arb_idx[sel];
        if (free) begin
            st_d.valid = 1'b0;
            if (active[0]) begin
                st_d.valid = 1'b1;
                st_d.qid   = '0;
            end else if (arb_found[sel]) begin
                st_d.valid    = 1'b1;
                st_d.qid      = win;
                st_d.ptr[sel] = win + QID_W'(1);
                if (arb_reload[sel]) begin
                    for (int i = 0; i < NUM_Q; i++) begin
                        if (arb_mask[sel][i]) st_d.credit[i] = weight[i];
                    end
                    st_d.credit[win] = weight[win] - WEIGHT_W'(1);
                end else begin
                    st_d.credit[win] = st_q.credit[win] - WEIGHT_W'(1);
                end
            end
            st_d.dest = q_dest[st_d.qid*DEST_W +: DEST_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gnt_valid = st_q.valid;
    assign gnt_qid   = st_q.qid;
    assign gnt_dest  = st_q.dest;

    // R8
    hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && !gnt_ready) |=> (gnt_valid && $stable(gnt_qid) && $stable(gnt_dest)));

    // R2
    q0_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (free && q_elig[0] && (q_weight[WEIGHT_W-1:0] != '0)) |=> (gnt_valid && gnt_qid == '0));

    // R4
    upper_tier_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (free && tiered_mode && !active[0] && ((active & arb_mask[ARB_UPPER]) != '0))
        |=> (gnt_valid && gnt_qid != '0 && int'(gnt_qid) < LOW_BASE));

    // R11
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (free && active == '0) |=> !gnt_valid);

    // R9
    busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (free && active != '0) |=> gnt_valid);
endmodule

// File: tb/task_sched_hwrr_bench.sv
module task_sched_hwrr_bench;
    localparam int NQ = 32;
    localparam int WW = 4;
    localparam int DW = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NQ-1:0]     q_elig = '0;
    logic [NQ*WW-1:0]  q_weight = '0;
    logic [NQ*DW-1:0]  q_dest = '0;
    logic              tiered_mode = 1'b0;
    logic              gnt_ready = 1'b1;
    logic              gnt_valid;
    logic [4:0]        gnt_qid;
    logic [DW-1:0]     gnt_dest;

    always #2.5 clk = ~clk;

    task_sched_hwrr u_task_sched_hwrr (
        .clk(clk), .rst_n(rst_n), .q_elig(q_elig), .q_weight(q_weight),
        .q_dest(q_dest), .tiered_mode(tiered_mode), .gnt_ready(gnt_ready),
        .gnt_valid(gnt_valid), .gnt_qid(gnt_qid), .gnt_dest(gnt_dest)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;

    // reference model state
    bit m_valid;
    int m_qid;
    int m_dest;
    int m_cred[NQ];
    int m_ptr[3];

    int cnt[NQ];
    int log_q[$];

    function automatic int wt(int q);
        return int'(q_weight[q*WW +: WW]);
    endfunction

    function automatic bit act(int q);
        return q_elig[q] && (wt(q) != 0);
    endfunction

    function automatic int lo_of(int t);
        return (t == 2) ? 16 : 1;
    endfunction

    function automatic int hi_of(int t);
        return (t == 1) ? 15 : 31;
    endfunction

    function automatic int scan(int t, bit need_credit);
        for (int k = 0; k < NQ; k++) begin
            int q;
            q = (m_ptr[t] + k) % NQ;
            if (q >= lo_of(t) && q <= hi_of(t) && act(q) && (!need_credit || m_cred[q] > 0))
                return q;
        end
        return -1;
    endfunction

    task automatic model_reset();
        m_valid = 0; m_qid = 0; m_dest = 0;
        for (int i = 0; i < NQ; i++) m_cred[i] = 0;
        for (int t = 0; t < 3; t++) m_ptr[t] = 0;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            model_reset();
        end else if (!m_valid || gnt_ready) begin
            int t;
            int q;
            bit up;
            m_valid = 0;
            if (act(0)) begin
                m_valid = 1; m_qid = 0;
            end else begin
                up = 0;
                for (int i = 1; i <= 15; i++) if (act(i)) up = 1;
                t = !tiered_mode ? 0 : (up ? 1 : 2);
                q = scan(t, 1);
                if (q < 0) begin
                    q = scan(t, 0);
                    if (q >= 0)
                        for (int i = lo_of(t); i <= hi_of(t); i++) m_cred[i] = wt(i);
                end
                if (q >= 0) begin
                    m_cred[q] = m_cred[q] - 1;
                    m_ptr[t] = (q + 1) % NQ;
                    m_valid = 1; m_qid = q;
                end
            end
            m_dest = int'(q_dest[m_qid*DW +: DW]);
        end
    end

    task automatic chk(bit ok, string req, int actv, int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, actv, expv);
        end
    endtask

    // per-cycle compare against the model, plus handshake log
    always @(negedge clk) begin
        if (rst_n) begin
            chk(gnt_valid === m_valid, "R9 valid", int'(gnt_valid), int'(m_valid));
            if (m_valid) begin
                chk(int'(gnt_qid) == m_qid, "R5 qid", int'(gnt_qid), m_qid);
                chk(int'(gnt_dest) == m_dest, "R10 dest", int'(gnt_dest), m_dest);
            end
            if (gnt_valid && gnt_ready) begin
                cnt[gnt_qid]++;
                log_q.push_back(int'(gnt_qid));
            end
        end
    end

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            finish_run();
        end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic clear_log();
        log_q.delete();
        for (int i = 0; i < NQ; i++) cnt[i] = 0;
    endtask

    task automatic do_reset(bit mode);
        rst_n = 0;
        tiered_mode = mode;
        step(3);
        clear_log();
        rst_n = 1;
    endtask

    initial begin
        int sumw;
        int rounds;
        int c[NQ];
        int hold_q;
        int hold_d;
        int exp_seq[12] = '{2,3,2,2,3,2,2,2,3,2,2,2};
        bit ok;

        for (int i = 0; i < NQ; i++) q_dest[i*DW +: DW] = DW'(i % 8);
        step(1);
        // R1: valid low during reset
        @(negedge clk);
        chk(gnt_valid == 1'b0, "R1 in reset", int'(gnt_valid), 0);
        step(1);
        do_reset(0);
        @(negedge clk);
        chk(gnt_valid == 1'b0, "R1 after release", int'(gnt_valid), 0);
        // R11: nothing eligible, no grant
        step(4);
        @(negedge clk);
        chk(gnt_valid == 1'b0, "R11 idle", int'(gnt_valid), 0);

        // R3 / R7: flat weights, queue 5 weight zero
        for (int i = 0; i < NQ; i++) q_weight[i*WW +: WW] = WW'((i % 3) + 1);
        q_weight[5*WW +: WW] = '0;
        q_elig = '1; q_elig[0] = 1'b0;
        do_reset(0);
        sumw = 0;
        for (int i = 1; i < NQ; i++) sumw += wt(i);
        rounds = 3;
        while (log_q.size() < rounds * sumw) step(1);
        for (int i = 0; i < NQ; i++) c[i] = 0;
        for (int k = 0; k < rounds * sumw; k++) c[log_q[k]]++;
        for (int i = 1; i < NQ; i++) begin
            if (i == 5) chk(c[i] == 0, "R7 zero weight count", c[i], 0);
            else        chk(c[i] == rounds * wt(i), "R3 weighted share", c[i], rounds * wt(i));
        end

        // R2: queue 0 dominates
        q_weight[0 +: WW] = WW'(1);
        q_elig[0] = 1'b1;
        clear_log();
        step(20);
        chk(log_q.size() >= 19, "R2 grant rate", log_q.size(), 19);
        ok = 1;
        for (int k = 1; k < log_q.size(); k++) if (log_q[k] != 0) ok = 0;
        chk(ok, "R2 queue0 strict", int'(ok), 1);
        q_elig[0] = 1'b0;
        step(3);

        // R8 / R10: stall holds the grant
        gnt_ready = 1'b0;
        step(2);
        @(negedge clk);
        hold_q = int'(gnt_qid); hold_d = int'(gnt_dest);
        chk(gnt_valid == 1'b1, "R8 valid during stall", int'(gnt_valid), 1);
        chk(hold_d == int'(q_dest[hold_q*DW +: DW]), "R10 dest tag", hold_d, int'(q_dest[hold_q*DW +: DW]));
        step(5);
        @(negedge clk);
        chk(gnt_valid == 1'b1, "R8 still valid", int'(gnt_valid), 1);
        chk(int'(gnt_qid) == hold_q, "R8 qid held", int'(gnt_qid), hold_q);
        chk(int'(gnt_dest) == hold_d, "R8 dest held", int'(gnt_dest), hold_d);
        gnt_ready = 1'b1;
        step(2);

        // R4: tiered mode
        q_elig = '1; q_elig[0] = 1'b0;
        do_reset(1);
        step(40);
        ok = 1;
        for (int k = 0; k < log_q.size(); k++) if (log_q[k] < 1 || log_q[k] > 15) ok = 0;
        chk(ok && log_q.size() > 30, "R4 upper tier only", log_q.size(), 39);
        q_elig = '0;
        for (int i = 16; i < NQ; i++) q_elig[i] = 1'b1;
        clear_log();
        step(30);
        ok = 1;
        for (int k = 1; k < log_q.size(); k++) if (log_q[k] < 16) ok = 0;
        chk(ok && log_q.size() > 20, "R4 lower tier served", log_q.size(), 29);

        // R5 / R6: credit exhaustion and pointer order
        q_elig = '0; q_elig[2] = 1'b1; q_elig[3] = 1'b1;
        q_weight[2*WW +: WW] = WW'(3);
        q_weight[3*WW +: WW] = WW'(1);
        do_reset(0);
        step(16);
        chk(log_q.size() >= 12, "R6 sequence length", log_q.size(), 12);
        for (int k = 0; k < 12; k++) begin
            if (k < log_q.size())
                chk(log_q[k] == exp_seq[k], "R6 sequence", log_q[k], exp_seq[k]);
        end

        // R11 again after work dries up
        q_elig = '0;
        step(3);
        @(negedge clk);
        chk(gnt_valid == 1'b0, "R11 drained", int'(gnt_valid), 0);

        done = 1;
        step(1);
        finish_run();
    end
endmodule